// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the bit-level slave engine of a two-wire serial memory. While a write transfer is in progress it gathers each received data byte into a one-page staging buffer. The page holds 2^OFFS_W bytes, 128 by default. Each byte lands at the current in-page offset. After every byte only the low offset bits of the word address advance, so a transfer that runs past the last byte of a page continues at the first byte of the same page, and earlier bytes at those offsets are replaced. Every offset written in the transfer is marked valid. The page number, the upper address bits, never moves.

A stop strobe arriving with at least one buffered byte starts a self-timed commit. The block raises `busy` for exactly `COMMIT_CYCLES` clocks. In the first 2^OFFS_W of those clocks it walks the offsets in ascending order, one per clock, and issues an array write only for offsets that were filled. All other locations of the page keep their old contents. While `busy` is high, every control input is ignored, and the protocol engine uses the flag to withhold acknowledges, including the acknowledge of the device address. Polling therefore succeeds again once `busy` drops. The word address counter is kept across operations and is presented on `cur_addr`.

Top module: `page_write_commit`

## Requirements
- R1: After a synchronous reset, `busy` and `arr_we` are low and `cur_addr` is zero.
- R2: With `busy` low, `addr_load` copies `addr_in` into `cur_addr` on the next clock and discards every byte buffered so far. `addr_load` has priority over `byte_vld` and `stop_evt` in the same clock.
- R3: With `busy` low, each `byte_vld` stores `byte_data` at offset `cur_addr[6:0]`. The offset then becomes (offset+1) mod 128, so offset 127 is followed by offset 0, and `cur_addr[15:7]` is unchanged.
- R4: When one offset is written more than once in a transfer, for example because more than 128 bytes were sent, only the last byte written there is committed.
- R5: A `stop_evt` with `busy` low, no `addr_load` or `byte_vld` in the same clock, and at least one buffered byte raises `busy` on the next clock. `busy` then stays high for exactly `COMMIT_CYCLES` clocks.
- R6: A `stop_evt` with no buffered byte does not raise `busy` and causes no array write.
- R7: In the k-th clock of a commit (k = 0 .. 127), `arr_we` is high exactly when offset k was written in the transfer. When it is high, `arr_addr` is {page, k} and `arr_wdata` is the byte stored at offset k. `arr_we` is never high while `busy` is low.
- R8: While `busy` is high, `addr_load`, `byte_vld` and `stop_evt` have no effect: `cur_addr` holds, and a byte offered then is neither buffered nor later committed.
- R9: When a commit ends, the buffer is empty and `cur_addr` keeps its value. Bytes that follow without a new `addr_load` continue from that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_load | input | 1 | Strobe: load the word address |
| addr_in | input | ADDR_W | Word address to load |
| byte_vld | input | 1 | Strobe: one data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Strobe: stop condition seen on the bus |
| busy | output | 1 | Commit in progress; acknowledges are refused |
| cur_addr | output | ADDR_W | Current word address counter |
| arr_we | output | 1 | Storage array write enable |
| arr_addr | output | ADDR_W | Storage array write address |
| arr_wdata | output | DATA_W | Storage array write data |

## Verification
The hardest condition to reach from the ports is a transfer that wraps the page, starting near the top offset and continuing through offset 127 into the low offsets, with enough bytes to overwrite locations already filled in the same transfer. The commit must then emit the surviving bytes with holes in between. The stimulus loads an address at offset 126 and sends a short burst across the boundary, and in a separate transfer it sends 130 bytes from offset 0. A behavioural model is checked on every clock of the walk. A further sequence offers address loads, bytes and stops during a commit, then issues a stop right after the commit. This exposes any byte that leaked into the buffer while it was frozen.

// File: rtl/pwc_pkg.sv
// Package: shared types for the page write commit block.
// Assumes: nothing beyond IEEE 1800-2017.
package pwc_pkg;
    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_COMMIT  = 1'b1
    } phase_e;
endpackage

// File: rtl/pwc_addr_ctr.sv
// Word address counter with in-page wrap.
// A load replaces the whole address. A step advances only the low OFFS_W bits
// and leaves the page bits untouched.
// Assumes: load and step are already gated by the caller against busy.
module pwc_addr_ctr #(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    // Load, or advance the in-page offset with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (step) begin
            addr_q[OFFS_W-1:0] <= addr_q[OFFS_W-1:0] + 1'b1;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/pwc_page_buf.sv
// One-page staging buffer with a valid flag per byte.
// Writes mark an entry valid, and clear drops every valid flag. The read port is
// combinational, for the commit walk.
// Assumes: wr_en and clr are never high together.
module pwc_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFFS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFFS_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int DEPTH = 1 << OFFS_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold the byte for one offset.
        always_ff @(posedge clk) begin
            if (wr_en && wr_off == OFFS_W'(g)) begin
                mem_q[g] <= wr_data;
            end
        end

        // Track whether this offset was written in the current transfer.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld_q[g] <= 1'b0;
            end else if (wr_en && wr_off == OFFS_W'(g)) begin
                vld_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data   = mem_q[rd_off];
    assign rd_valid  = vld_q[rd_off];
    assign any_valid = |vld_q;
endmodule

// File: rtl/pwc_commit_timer.sv
// Commit sequencer.
// Start raises busy for COMMIT_CYCLES clocks. During the first 2^OFFS_W of those
// clocks it presents one scan offset per clock, in ascending order.
// Assumes: COMMIT_CYCLES >= 1; a value below 2^OFFS_W truncates the walk.
module pwc_commit_timer
    import pwc_pkg::*;
#(
    parameter int COMMIT_CYCLES = 200,
    parameter int OFFS_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              scan_live,
    output logic [OFFS_W-1:0] scan_off
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [OFFS_W:0]    scan_q;

    // Phase and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COLLECT;
            cnt_q   <= '0;
        end else if (phase_q == PH_COLLECT) begin
            if (start) begin
                phase_q <= PH_COMMIT;
                cnt_q   <= CNT_W'(COMMIT_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            phase_q <= PH_COLLECT;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Scan index over the page offsets.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            scan_q <= '0;
        end else if (scan_live) begin
            scan_q <= scan_q + 1'b1;
        end
    end

    assign busy      = (phase_q == PH_COMMIT);
    assign done      = busy && (cnt_q == '0);
    assign scan_live = busy && !scan_q[OFFS_W];
    assign scan_off  = scan_q[OFFS_W-1:0];
endmodule

// File: rtl/page_write_commit.sv
// Top: page write buffer with timed commit.
// Gates the bus-side strobes with busy, feeds the address counter and the page
// buffer, and drives the array write port from the commit walk.
// Assumes: strobes are single-clock pulses from the slave engine.
// Priority in one clock is addr_load, then byte_vld, then stop_evt.
module page_write_commit #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int OFFS_W        = 7,
    parameter int COMMIT_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    logic              idle;
    logic              do_load;
    logic              do_step;
    logic              do_start;
    logic              done;
    logic              scan_live;
    logic [OFFS_W-1:0] scan_off;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              buf_any;

    assign idle     = !busy;
    assign do_load  = idle && addr_load;
    assign do_step  = idle && !addr_load && byte_vld;
    assign do_start = idle && !addr_load && !byte_vld && stop_evt && buf_any;

    pwc_addr_ctr #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_addr (addr_in),
        .step      (do_step),
        .addr      (cur_addr)
    );

    pwc_page_buf #(
        .DATA_W (DATA_W),
        .OFFS_W (OFFS_W)
    ) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_step),
        .wr_off    (cur_addr[OFFS_W-1:0]),
        .wr_data   (byte_data),
        .clr       (do_load || done),
        .rd_off    (scan_off),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (buf_any)
    );

    pwc_commit_timer #(
        .COMMIT_CYCLES (COMMIT_CYCLES),
        .OFFS_W        (OFFS_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (do_start),
        .busy      (busy),
        .done      (done),
        .scan_live (scan_live),
        .scan_off  (scan_off)
    );

    assign arr_we    = scan_live && rd_valid;
    assign arr_addr  = {cur_addr[ADDR_W-1:OFFS_W], scan_off};
    assign arr_wdata = rd_data;
endmodule

// File: rtl/pwc_checker.sv
// Property checker for page_write_commit, attached through bind.
// Assumes: the reset is synchronous and active low.
module pwc_checker #(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_in,
    input logic              byte_vld,
    input logic              stop_evt,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              buf_any
);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load && !busy |=> cur_addr == $past(addr_in));

    assert_offset_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld && !addr_load && !busy |=>
            cur_addr[OFFS_W-1:0] == OFFS_W'($past(cur_addr[OFFS_W-1:0]) + 1'b1)
            && $stable(cur_addr[ADDR_W-1:OFFS_W]));

    assert_commit_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt && !busy && !addr_load && !byte_vld && buf_any |=> busy);

    assert_empty_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt && !busy && !buf_any |=> !busy);

    assert_no_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_we);

    assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:OFFS_W]));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));
endmodule

bind page_write_commit pwc_checker #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W)
) i_pwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_vld  (byte_vld),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .cur_addr  (cur_addr),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .buf_any   (buf_any)
);

// File: tb/test_page_write_commit.sv
// Bench: a behavioural reference model, compared against the design on every clock.
module test_page_write_commit;
    localparam int COMMIT = 200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_load;
    logic [15:0] addr_in;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        stop_evt;
    logic        busy;
    logic [15:0] cur_addr;
    logic        arr_we;
    logic [15:0] arr_addr;
    logic [7:0]  arr_wdata;

    int vectors = 0;
    int errors  = 0;
    string req  = "R1";

    // Reference model state.
    bit         m_busy;
    int         m_rem;
    int         m_scan;
    logic [8:0] m_page;
    logic [6:0] m_off;
    logic [7:0] m_buf [int];

    always #2 clk = ~clk;

    page_write_commit #(.COMMIT_CYCLES(COMMIT)) i_page_write_commit (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .busy(busy), .cur_addr(cur_addr), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic fail(string what, logic [15:0] got, logic [15:0] exp);
        errors++;
        $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    endtask

    // Compare the outputs with the model state after the last edge.
    task automatic compare();
        bit exp_we;
        vectors++;
        exp_we = m_busy && m_scan < 128 && m_buf.exists(m_scan);
        if (busy !== m_busy) fail("busy", 16'(busy), 16'(m_busy));
        if (cur_addr !== {m_page, m_off}) fail("cur_addr", cur_addr, {m_page, m_off});
        if (arr_we !== exp_we) fail("arr_we", 16'(arr_we), 16'(exp_we));
        if (exp_we && arr_we === 1'b1) begin
            if (arr_addr !== {m_page, 7'(m_scan)}) fail("arr_addr", arr_addr, {m_page, 7'(m_scan)});
            if (arr_wdata !== m_buf[m_scan]) fail("arr_wdata", 16'(arr_wdata), 16'(m_buf[m_scan]));
        end
    endtask

    // One clock: check, drive, then advance the model to the next edge.
    task automatic cyc(bit ld, logic [15:0] a, bit bv, logic [7:0] bd, bit st);
        @(negedge clk);
        compare();
        addr_load = ld; addr_in = a; byte_vld = bv; byte_data = bd; stop_evt = st;
        if (m_busy) begin
            m_scan++;
            m_rem--;
            if (m_rem == 0) begin
                m_busy = 0;
                m_buf.delete();
            end
        end else if (ld) begin
            m_page = a[15:7];
            m_off  = a[6:0];
            m_buf.delete();
        end else if (bv) begin
            m_buf[int'(m_off)] = bd;
            m_off = m_off + 7'd1;
        end else if (st && m_buf.size() > 0) begin
            m_busy = 1;
            m_rem  = COMMIT;
            m_scan = 0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 8'h0, 0);
    endtask

    task automatic wbyte(logic [7:0] d);
        cyc(0, 16'h0, 1, d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0; addr_load = 0; addr_in = 0; byte_vld = 0; byte_data = 0; stop_evt = 0;
        m_busy = 0; m_rem = 0; m_scan = 0; m_page = 0; m_off = 0;
        repeat (3) @(negedge clk);
        req = "R1";   // reset state
        compare();
        rst_n = 1'b1;

        req = "R6";   // stop with an empty buffer
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(4);

        req = "R5";   // short partial page, timed commit
        cyc(1, 16'h1234, 0, 8'h0, 0);
        wbyte(8'hA1); wbyte(8'hA2); wbyte(8'hA3);
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(COMMIT + 3);

        req = "R3";   // burst crossing the top offset into the low ones
        cyc(1, {9'h1F0, 7'd126}, 0, 8'h0, 0);
        for (int i = 0; i < 5; i++) wbyte(8'h50 + 8'(i));
        req = "R7";
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(COMMIT + 2);

        req = "R4";   // 130 bytes: offsets 0 and 1 overwritten
        cyc(1, {9'h003, 7'd0}, 0, 8'h0, 0);
        for (int i = 0; i < 130; i++) wbyte(8'(i * 3 + 7));
        cyc(0, 16'h0, 0, 8'h0, 1);
        req = "R8";   // traffic during the commit is ignored
        idle(5);
        cyc(1, 16'hBEEF, 0, 8'h0, 0);
        wbyte(8'hEE);
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(COMMIT);
        cyc(0, 16'h0, 0, 8'h0, 1);   // must not start: nothing buffered
        idle(4);

        req = "R9";   // continue from the retained offset without a load
        wbyte(8'h11); wbyte(8'h22);
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(COMMIT + 2);

        req = "R2";   // a load discards earlier bytes
        cyc(1, {9'h100, 7'd10}, 0, 8'h0, 0);
        wbyte(8'h77); wbyte(8'h78);
        cyc(1, {9'h101, 7'd20}, 0, 8'h0, 0);
        wbyte(8'h99);
        cyc(0, 16'h0, 0, 8'h0, 1);
        idle(COMMIT + 2);

        report();
    end
endmodule